// File: doc/BRIEF.md
# Triangular Chirp Sine Synthesizer

This block is a direct digital synthesis source whose output is a sine wave with a linearly swept frequency. The sweep runs up and then down in a repeating triangle. A sweep controller moves a frequency tuning word between a lower and an upper limit in equal steps. A phase accumulator adds that word on every enabled clock. The accumulator value addresses a sine table that is computed at elaboration. The table returns an unsigned offset-binary sample that can drive a DAC. The output frequency is Fclk × word / 2^PW, and the resolution is Fclk / 2^PW.

The sample, the delayed phase that addressed it, and the live tuning word all leave the block as registered outputs. With the default PW = 10 and a 100 MHz clock, the upper limit of 204 gives about 20 MHz. A word of 51 gives about 5 MHz. The enable input pauses the whole generator without losing its place.

Top module: `chirp_dds`

## Requirements
- R1: While reset is high at a clock edge, after that edge phase_o is 0, ftw_o is 0 and sample_o is the mid-scale code 2^(PW-1) (512 by default).
- R2: On each rising edge with en high, the internal phase advances by the current tuning word modulo 2^PW. phase_o shows that internal phase one cycle late.
- R3: sample_o equals round((sin(2π·p/2^PW) + 1) · 2^(PW-1)), where p is the value on phase_o in the same cycle. The full phase is used as the table index, with no folding. sample_o is PW+1 bits wide, so the peak 2^PW fits.
- R4: After reset the controller is idle for one enabled edge and then enters the rise phase. At the first rise edge ftw_o becomes MIN + STEP, where STEP = (MAX − MIN) / STEPS using integer division.
- R5: In the rise phase a count k runs from 1 to STEPS and ftw_o becomes MIN + STEP·k. After k = STEPS, one further enabled edge holds ftw_o, reloads k to 1 and moves to the fall phase.
- R6: In the fall phase ftw_o becomes MAX − STEP·k for k = 1..STEPS. One hold edge then returns to the rise phase, and the triangle repeats without end.
- R7: At the top of every rise, ftw_o reaches exactly MIN + STEP·STEPS (201 by default) and never exceeds MAX.
- R8: On an edge with en low, the internal phase, the count, the sweep phase and ftw_o all keep their values. phase_o is therefore unchanged one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable; low pauses phase and sweep |
| ftw_o | output | PW | Current frequency tuning word |
| phase_o | output | PW | Phase that addressed the current sample |
| sample_o | output | PW+1 | Unsigned offset-binary sine sample |

## Verification
ftw_o changes on the same edge on which the sweep logic sees en high. phase_o and sample_o carry the phase value from before that edge, so they lag the internal accumulator by one edge and stay aligned with each other. The bench holds a cycle-accurate model that is updated on the same edges as the design. It compares all three outputs on the falling edge, after every register has settled. A sample is checked against the table formula evaluated at the phase_o value of that cycle, so any misalignment between the two outputs shows up as a miscompare.

// File: rtl/chirp_dds_pkg.sv
package chirp_dds_pkg;

  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_UP   = 2'd1,
    SW_DOWN = 2'd2
  } sweep_st_t;

  localparam real TWO_PI = 6.283185307179586;

  // Offset-binary sine entry for index n of a 2**pw point table
  function automatic int sine_code(int n, int pw);
    real x;
    real full;
    full = 2.0 ** pw;
    x = $sin(TWO_PI * n / full);
    return $rtoi((x + 1.0) * full / 2.0 + 0.5);
  endfunction

endpackage

// File: rtl/chirp_sweep.sv
module chirp_sweep
  import chirp_dds_pkg::*;
#(
  parameter int PW    = 10,
  parameter int MIN   = 1,
  parameter int MAX   = 204,
  parameter int STEPS = 200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [PW-1:0] ftw
);

  localparam int STEP = (MAX - MIN) / STEPS;
  localparam int CW   = $clog2(STEPS + 2);

  sweep_st_t     st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= SW_IDLE;
      cnt <= CW'(1);
      ftw <= '0;
    end else if (en) begin
      case (st)
        SW_IDLE: begin
          st  <= SW_UP;
          cnt <= CW'(1);
        end
        SW_UP: begin
          if (int'(cnt) <= STEPS) begin
            cnt <= cnt + CW'(1);
            ftw <= PW'(MIN + STEP * int'(cnt));
          end else begin
            cnt <= CW'(1);
            st  <= SW_DOWN;
          end
        end
        SW_DOWN: begin
          if (int'(cnt) <= STEPS) begin
            cnt <= cnt + CW'(1);
            ftw <= PW'(MAX - STEP * int'(cnt));
          end else begin
            cnt <= CW'(1);
            st  <= SW_UP;
          end
        end
        default: st <= SW_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phase_acc.sv
module phase_acc #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [PW-1:0] ftw,
  output logic [PW-1:0] acc,
  output logic [PW-1:0] phase_d
);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      phase_d <= '0;
    end else begin
      phase_d <= acc;
      if (en) acc <= acc + ftw;
    end
  end

endmodule

// File: rtl/sine_rom.sv
module sine_rom
  import chirp_dds_pkg::*;
#(
  parameter int PW = 10,
  localparam int DW    = PW + 1,
  localparam int DEPTH = 1 << PW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] addr,
  output logic [DW-1:0] dout
);

  localparam logic [DW-1:0] MID = DW'(1 << (PW - 1));

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(sine_code(i, PW));
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= MID;
    else     dout <= mem[addr];
  end

endmodule

// File: rtl/chirp_dds.sv
module chirp_dds #(
  parameter int PW    = 10,
  parameter int MIN   = 1,
  parameter int MAX   = 204,
  parameter int STEPS = 200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [PW-1:0] ftw_o,
  output logic [PW-1:0] phase_o,
  output logic [PW:0]   sample_o
);

  logic [PW-1:0] acc;

  chirp_sweep #(.PW(PW), .MIN(MIN), .MAX(MAX), .STEPS(STEPS)) u_sweep (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .ftw (ftw_o)
  );

  phase_acc #(.PW(PW)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .ftw     (ftw_o),
    .acc     (acc),
    .phase_d (phase_o)
  );

  sine_rom #(.PW(PW)) u_rom (
    .clk  (clk),
    .rst  (rst),
    .addr (acc),
    .dout (sample_o)
  );

endmodule

// File: rtl/chirp_dds_chk.sv
module chirp_dds_chk #(
  parameter int PW  = 10,
  parameter int MAX = 204
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [PW-1:0] ftw_o,
  input logic [PW-1:0] phase_o,
  input logic [PW:0]   sample_o
);

  logic run_q;
  logic hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      run_q  <= en;
      hold_q <= !en;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (phase_o == '0 && ftw_o == '0));

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |=> phase_o == PW'($past(phase_o) + $past(ftw_o, 2)));

  // R3
  sample_range_chk: assert property (@(posedge clk) disable iff (rst)
    sample_o <= (PW + 1)'(1 << PW));

  // R7
  ftw_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(ftw_o) <= MAX);

  // R8
  ftw_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(ftw_o));

  // R8
  phase_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> $stable(phase_o));

endmodule

bind chirp_dds chirp_dds_chk #(.PW(PW), .MAX(MAX)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .ftw_o    (ftw_o),
  .phase_o  (phase_o),
  .sample_o (sample_o)
);

// File: tb/chirp_dds_test.sv
module chirp_dds_test;

  localparam int PW    = 10;
  localparam int MIN   = 1;
  localparam int MAX   = 204;
  localparam int STEPS = 200;
  localparam int STEP  = (MAX - MIN) / STEPS;
  localparam int FULL  = 1 << PW;
  localparam int TOP   = MIN + STEP * STEPS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en  = 1'b1;
  logic [PW-1:0] ftw_o;
  logic [PW-1:0] phase_o;
  logic [PW:0]   sample_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  bit live = 1'b0;
  int tops = 0;

  always #5 clk = ~clk;

  chirp_dds #(.PW(PW), .MIN(MIN), .MAX(MAX), .STEPS(STEPS)) uut (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .ftw_o    (ftw_o),
    .phase_o  (phase_o),
    .sample_o (sample_o)
  );

  function automatic int ref_sine(int p);
    real x;
    x = $sin(6.283185307179586 * p / (1.0 * FULL));
    return $rtoi((x + 1.0) * FULL / 2.0 + 0.5);
  endfunction

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: 0 idle, 1 rise, 2 fall
  int m_st = 0, m_cnt = 1, m_ftw = 0, m_acc = 0, m_ph = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_st <= 0; m_cnt <= 1; m_ftw <= 0; m_acc <= 0; m_ph <= 0;
    end else begin
      m_ph <= m_acc;
      if (en) begin
        m_acc <= (m_acc + m_ftw) % FULL;
        case (m_st)
          0: begin m_st <= 1; m_cnt <= 1; end
          1: if (m_cnt <= STEPS) begin
               m_cnt <= m_cnt + 1; m_ftw <= MIN + STEP * m_cnt;
             end else begin m_cnt <= 1; m_st <= 2; end
          default: if (m_cnt <= STEPS) begin
               m_cnt <= m_cnt + 1; m_ftw <= MAX - STEP * m_cnt;
             end else begin m_cnt <= 1; m_st <= 1; end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (live && !done) begin
      chk("R5 R6 ftw", int'(ftw_o), m_ftw);
      chk("R2 R8 phase", int'(phase_o), m_ph);
      chk("R3 sample", int'(sample_o), ref_sine(m_ph));
      if (m_ftw == TOP && m_st == 1) begin
        tops++;
        chk("R7 top", int'(ftw_o), TOP);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    miscompares++;
    vectors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 phase", int'(phase_o), 0);
    chk("R1 ftw", int'(ftw_o), 0);
    chk("R1 sample", int'(sample_o), FULL / 2);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 idle", int'(ftw_o), 0);
    @(negedge clk);
    chk("R4 first rise", int'(ftw_o), MIN + STEP);
    live = 1'b1;
    // Full triangles with en held high
    repeat (900) @(negedge clk);
    // R8: long pause
    en = 1'b0;
    repeat (20) @(negedge clk);
    en = 1'b1;
    // Random enable pattern
    for (int i = 0; i < 3000; i++) begin
      en = ($urandom % 5) != 0;
      @(negedge clk);
    end
    // Mid-run reset
    rst = 1'b1;
    en = 1'b1;
    @(negedge clk);
    chk("R1 rereset ftw", int'(ftw_o), 0);
    chk("R1 rereset phase", int'(phase_o), 0);
    rst = 1'b0;
    repeat (600) @(negedge clk);
    chk("R7 tops seen", (tops >= 3) ? 1 : 0, 1);
    finish_run();
  end

endmodule